// File: doc/BRIEF.md
# Stacked-Carrier PWM Comparator for One Multilevel Inverter Leg

This block produces the switch commands for a single phase leg of an inverter with `LEVELS` output voltage levels. It holds one triangular carrier for each of the `LEVELS-1` switch levels. The carriers are stacked into adjacent bands that are centred on zero, so that a signed reference sample can be compared against all of them in parallel. Each comparison decides whether the switch pair for its level conducts. The registered results come out as on-commands and matching off-commands. An output level index gives the number of levels switched on.

All carriers come from one shared up/down counter, so they share one frequency and one amplitude. A disposition select chooses which bands see the counter in its true form and which see it mirrored, which shifts those bands by half a carrier period. Three arrangements are available: all bands in phase, the lower half opposed to the upper half, and each band alternating with its neighbours. The carrier position at reset is taken from a phase-offset input. This sets the displacement angle between the carrier set and the reference, and that angle changes how many switch transitions happen in each modulation cycle. Generating the reference, inserting dead time and driving the gates are done outside this block.

Top module: `mlpwm_leg`

## Requirements
- R1: While `rst` is high on a rising clock edge, `gate_on` becomes all zeros, `gate_off` becomes all ones and `level` becomes 0.
- R2: The shared counter `t` moves by one per clock between 0 and P=`half_period`. Counting up, it reaches P and then turns down. Counting down, it reaches 0 and then turns up. One full carrier period is 2P clocks.
- R3: The carrier of band k (k = 0 .. LEVELS-2) equals (2k-(LEVELS-1))*P + 2c. Here c is t, or P-t when band k is mirrored. Band k therefore spans [(2k-(LEVELS-1))P, (2k-(LEVELS-1)+2)P], the bands touch end to end, and the stack is centred on zero.
- R4: `gate_on[k]` is 1 exactly when the signed `ref_in` is strictly greater than the carrier of band k. This result is registered, so it appears one clock after the edge that sampled `ref_in` and `t`.
- R5: With `disp_mode` = 0, no band is mirrored (all carriers in phase). The value 3 behaves the same as 0. In this mode `gate_on` is always a thermometer code filled from bit 0.
- R6: With `disp_mode` = 1, band k is mirrored when 2k+2 <= LEVELS-1, which is every band lying wholly below zero. A band that straddles zero counts as an upper band.
- R7: With `disp_mode` = 2, every odd-numbered band k is mirrored, so that neighbouring bands are opposed.
- R8: On reset, with offset d=`phase_off`: t is loaded with d and counts up if d < P. It is loaded with 2P-d and counts down if P <= d < 2P. Otherwise it is loaded with 0 and counts up.
- R9: `gate_off` is always the bitwise complement of `gate_on`.
- R10: `level` equals the number of ones in `gate_on`, from 0 to LEVELS-1.
- R11: A reference above (LEVELS-1)*P turns every level on. A reference at or below -(LEVELS-1)*P turns every level off, whatever the counter position and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the carrier phase |
| ref_in | input | REF_W | Signed reference sample |
| phase_off | input | CNT_W+1 | Carrier phase offset applied at reset, in clocks (0 .. 2P-1) |
| disp_mode | input | 2 | Carrier disposition: 0 in phase, 1 halves opposed, 2 alternating, 3 as 0 |
| half_period | input | CNT_W | Carrier peak count P; full carrier period is 2P clocks |
| gate_on | output | LEVELS-1 | Registered on-command, one bit per switch level |
| gate_off | output | LEVELS-1 | Registered complementary off-command |
| level | output | $clog2(LEVELS) | Number of levels switched on |

## Verification
The properties assume that `half_period` is at least 1 and changes only while reset is held. They also assume that `phase_off` stays below 2P and that `ref_in` fits its signed width. The counter bound, the step rule and the saturation property each count on the counter never exceeding the current peak. The bench therefore programs the peak and the offset together with reset, and only moves the reference and the disposition mode between clock edges. It tracks the counter with its own model and predicts every band comparison from the carrier formula. It also covers each mode, several reset offsets, and references on both sides of the stack edges.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

    typedef enum logic [1:0] {
        DISP_INPHASE   = 2'd0,
        DISP_HALVES    = 2'd1,
        DISP_ALTERNATE = 2'd2,
        DISP_SPARE     = 2'd3
    } disp_e;

    // Decide whether band idx sees the mirrored counter (half-period shift).
    function automatic logic band_mirrored(input disp_e mode, input int idx, input int nbands);
        logic mir;
        case (mode)
            DISP_HALVES:    mir = ((2 * idx + 2) <= nbands);
            DISP_ALTERNATE: mir = (idx % 2) == 1;
            default:        mir = 1'b0;
        endcase
        return mir;
    endfunction

endpackage

// File: rtl/mlpwm_tri_counter.sv
module mlpwm_tri_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] half_period,
    input  logic [CNT_W:0]   phase_off,
    output logic [CNT_W-1:0] tri_val
);

    logic           going_up;
    logic [CNT_W:0] peak_ext;
    logic [CNT_W:0] two_peak;
    logic [CNT_W:0] inc_ext;

    always_comb begin
        peak_ext = {1'b0, half_period};
        two_peak = {half_period, 1'b0};
        inc_ext  = {1'b0, tri_val} + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            // R8: phase preload
            if (phase_off < peak_ext) begin
                tri_val  <= phase_off[CNT_W-1:0];
                going_up <= 1'b1;
            end else if (phase_off < two_peak) begin
                tri_val  <= CNT_W'(two_peak - phase_off);
                going_up <= 1'b0;
            end else begin
                tri_val  <= '0;
                going_up <= 1'b1;
            end
        end else if (going_up) begin
            if (inc_ext >= peak_ext) begin
                tri_val  <= half_period;
                going_up <= 1'b0;
            end else begin
                tri_val  <= inc_ext[CNT_W-1:0];
            end
        end else begin
            if (tri_val > half_period) begin
                tri_val  <= half_period;
            end else if (tri_val <= CNT_W'(1)) begin
                tri_val  <= '0;
                going_up <= 1'b1;
            end else begin
                tri_val  <= tri_val - 1'b1;
            end
        end
    end

    p_tri_bound_r2: assert property (@(posedge clk) disable iff (rst)
        $stable(half_period) |-> (tri_val <= half_period));

    p_tri_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(half_period) && ($past(tri_val) > 0) && ($past(tri_val) < half_period))
        |-> ((tri_val == $past(tri_val) + 1'b1) || (tri_val + 1'b1 == $past(tri_val))));

endmodule

// File: rtl/mlpwm_band_cmp.sv
module mlpwm_band_cmp
    import mlpwm_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int REF_W  = 12,
    parameter int CMP_W  = 16,
    parameter int NBANDS = 4,
    parameter int IDX    = 0
) (
    input  logic                    [CNT_W-1:0] half_period,
    input  logic                    [CNT_W-1:0] tri_val,
    input  disp_e                               disp_mode,
    input  logic signed             [REF_W-1:0] ref_in,
    output logic                                above
);

    localparam int BASE_MUL = 2 * IDX - NBANDS;

    logic               mirror;
    logic signed [CMP_W-1:0] peak_s;
    logic signed [CMP_W-1:0] tri_s;
    logic signed [CMP_W-1:0] pos_s;
    logic signed [CMP_W-1:0] carrier_s;
    logic signed [CMP_W-1:0] ref_s;

    always_comb begin
        mirror    = band_mirrored(disp_mode, IDX, NBANDS);
        peak_s    = signed'(CMP_W'(half_period));
        tri_s     = signed'(CMP_W'(tri_val));
        pos_s     = mirror ? (peak_s - tri_s) : tri_s;
        // R3: band base plus twice the in-band position
        carrier_s = CMP_W'(BASE_MUL) * peak_s + (pos_s <<< 1);
        ref_s     = CMP_W'(ref_in);
        // R4: strict comparison
        above     = ref_s > carrier_s;
    end

endmodule

// File: rtl/mlpwm_leg.sv
module mlpwm_leg
    import mlpwm_pkg::*;
#(
    parameter int LEVELS = 5,
    parameter int CNT_W  = 8,
    parameter int REF_W  = 12
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic signed [REF_W-1:0]               ref_in,
    input  logic        [CNT_W:0]                 phase_off,
    input  logic        [1:0]                     disp_mode,
    input  logic        [CNT_W-1:0]               half_period,
    output logic        [LEVELS-2:0]              gate_on,
    output logic        [LEVELS-2:0]              gate_off,
    output logic        [$clog2(LEVELS)-1:0]      level
);

    localparam int NBANDS = LEVELS - 1;
    localparam int LVL_W  = $clog2(LEVELS);
    localparam int CAR_W  = CNT_W + $clog2(NBANDS + 1) + 2;
    localparam int CMP_W  = ((REF_W > CAR_W) ? REF_W : CAR_W) + 1;

    disp_e              mode_e;
    logic [CNT_W-1:0]   tri_val;
    logic [NBANDS-1:0]  cmp_bits;
    logic [LVL_W-1:0]   lvl_next;

    assign mode_e = disp_e'(disp_mode);

    mlpwm_tri_counter #(.CNT_W(CNT_W)) u_tri (
        .clk        (clk),
        .rst        (rst),
        .half_period(half_period),
        .phase_off  (phase_off),
        .tri_val    (tri_val)
    );

    for (genvar k = 0; k < NBANDS; k++) begin : g_band
        mlpwm_band_cmp #(
            .CNT_W (CNT_W),
            .REF_W (REF_W),
            .CMP_W (CMP_W),
            .NBANDS(NBANDS),
            .IDX   (k)
        ) u_cmp (
            .half_period(half_period),
            .tri_val    (tri_val),
            .disp_mode  (mode_e),
            .ref_in     (ref_in),
            .above      (cmp_bits[k])
        );
    end

    always_comb begin
        lvl_next = '0;
        for (int k = 0; k < NBANDS; k++) begin
            lvl_next = lvl_next + LVL_W'(cmp_bits[k]);
        end
    end

    // All levels update on the same edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            gate_on  <= '0;
            gate_off <= '1;
            level    <= '0;
        end else begin
            gate_on  <= cmp_bits;
            gate_off <= ~cmp_bits;
            level    <= lvl_next;
        end
    end

    logic signed [CMP_W-1:0] ref_chk;
    logic signed [CMP_W-1:0] stack_top;
    assign ref_chk   = CMP_W'(ref_in);
    assign stack_top = CMP_W'(NBANDS) * signed'(CMP_W'(half_period));

    p_complement_r9: assert property (@(posedge clk) disable iff (rst)
        gate_off == ~gate_on);

    p_level_count_r10: assert property (@(posedge clk) disable iff (rst)
        level == LVL_W'($countones(gate_on)));

    p_thermo_inphase_r5: assert property (@(posedge clk) disable iff (rst)
        (((disp_mode == 2'd0) || (disp_mode == 2'd3)) && $stable(half_period))
        |=> ((gate_on & (gate_on + 1'b1)) == '0));

    p_sat_high_r11: assert property (@(posedge clk) disable iff (rst)
        ($stable(half_period) && (ref_chk > stack_top)) |=> (&gate_on));

    p_sat_low_r11: assert property (@(posedge clk) disable iff (rst)
        ($stable(half_period) && (ref_chk <= -stack_top)) |=> (gate_on == '0));

endmodule

// File: tb/test_mlpwm_leg.sv
module test_mlpwm_leg;

    localparam int CLK_PERIOD = 10;
    localparam int LEVELS     = 5;
    localparam int CNT_W      = 8;
    localparam int REF_W      = 12;
    localparam int NB         = LEVELS - 1;
    localparam int LVL_W      = $clog2(LEVELS);

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic signed [REF_W-1:0]  ref_in = '0;
    logic        [CNT_W:0]    phase_off = '0;
    logic        [1:0]        disp_mode = 2'd0;
    logic        [CNT_W-1:0]  half_period = 8'd10;
    logic        [NB-1:0]     gate_on;
    logic        [NB-1:0]     gate_off;
    logic        [LVL_W-1:0]  level;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int m_t;
    bit m_up;

    mlpwm_leg #(.LEVELS(LEVELS), .CNT_W(CNT_W), .REF_W(REF_W)) i_mlpwm_leg (
        .clk        (clk),
        .rst        (rst),
        .ref_in     (ref_in),
        .phase_off  (phase_off),
        .disp_mode  (disp_mode),
        .half_period(half_period),
        .gate_on    (gate_on),
        .gate_off   (gate_off),
        .level      (level)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected comparator bits from the R3..R7 carrier formula.
    function automatic int model_bits(input int r, input int t, input int mode, input int p);
        int bits = 0;
        for (int k = 0; k < NB; k++) begin
            bit inv;
            int c;
            int car;
            if (mode == 1)      inv = (2 * k + 2) <= NB;
            else if (mode == 2) inv = (k % 2) == 1;
            else                inv = 1'b0;
            c   = inv ? (p - t) : t;
            car = (2 * k - NB) * p + 2 * c;
            if (r > car) bits = bits | (1 << k);
        end
        return bits;
    endfunction

    function automatic int popcnt(input int v);
        int n = 0;
        for (int k = 0; k < NB; k++) n += (v >> k) & 1;
        return n;
    endfunction

    // R2 counter model
    task automatic model_advance(input int p);
        if (m_up) begin
            if (m_t + 1 >= p) begin m_t = p; m_up = 1'b0; end
            else m_t = m_t + 1;
        end else begin
            if (m_t <= 1) begin m_t = 0; m_up = 1'b1; end
            else m_t = m_t - 1;
        end
    endtask

    task automatic do_reset(input int ph, input int p);
        @(negedge clk);
        rst         = 1'b1;
        phase_off   = (CNT_W+1)'(ph);
        half_period = CNT_W'(p);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 gate_on at reset", int'(gate_on), 0);
        chk("R1 gate_off at reset", int'(gate_off), (1 << NB) - 1);
        chk("R1 level at reset", int'(level), 0);
        // R8 preload model
        if (ph < p)          begin m_t = ph;         m_up = 1'b1; end
        else if (ph < 2 * p) begin m_t = 2 * p - ph; m_up = 1'b0; end
        else                 begin m_t = 0;          m_up = 1'b1; end
        rst = 1'b0;
    endtask

    task automatic step_check(input string req);
        int exp;
        int p;
        @(posedge clk);
        p   = int'(half_period);
        exp = model_bits(int'(ref_in), m_t, int'(disp_mode), p);
        model_advance(p);
        @(negedge clk);
        chk(req, int'(gate_on), exp);
        chk("R9 complement", int'(gate_off), (~exp) & ((1 << NB) - 1));
        chk("R10 level count", int'(level), popcnt(exp));
    endtask

    task automatic run_refs(input int mode, input string req, input int r0, input int r1, input int r2);
        int refs [3];
        refs[0] = r0; refs[1] = r1; refs[2] = r2;
        disp_mode = 2'(mode);
        foreach (refs[i]) begin
            ref_in = REF_W'(refs[i]);
            for (int s = 0; s < 2 * int'(half_period) + 2; s++) step_check(req);
        end
    endtask

    task automatic t_reset();
        do_reset(0, 10);
    endtask

    task automatic t_inphase();
        run_refs(0, "R4 R5 R2 R3 in-phase compare", -35, 0, 13);
        run_refs(0, "R4 R5 in-phase compare", 38, -5, 21);
        run_refs(3, "R5 mode 3 acts as in-phase", 7, -22, 30);
    endtask

    task automatic t_halves();
        run_refs(1, "R6 halves-opposed compare", -25, 7, 0);
    endtask

    task automatic t_alternate();
        run_refs(2, "R7 alternating compare", -12, 3, 27);
    endtask

    task automatic t_phase();
        do_reset(13, 10);
        run_refs(0, "R8 offset past peak", 5, 5, 5);
        do_reset(4, 10);
        run_refs(2, "R8 offset before peak", -15, 15, 15);
        do_reset(25, 10);
        run_refs(1, "R8 offset out of range", 9, 9, 9);
    endtask

    task automatic t_saturate();
        do_reset(0, 10);
        for (int mode = 0; mode < 3; mode++) begin
            disp_mode = 2'(mode);
            ref_in = REF_W'(41);
            for (int s = 0; s < 21; s++) begin
                step_check("R11 above stack");
                chk("R11 all on", int'(gate_on), (1 << NB) - 1);
            end
            ref_in = REF_W'(-40);
            for (int s = 0; s < 21; s++) begin
                step_check("R11 at stack floor");
                chk("R11 all off", int'(gate_on), 0);
            end
        end
    endtask

    initial begin
        t_reset();
        t_inphase();
        t_halves();
        t_alternate();
        t_phase();
        t_saturate();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule